// File: doc/BRIEF.md
# Inbound Address Window Translator

This block implements one inbound memory window of a bridge that carries memory cycles from an external bus onto an internal bus. Software programs three 32-bit registers: a limit that acts as a size mask, a base address that places the window, and a translation value that says where the window lands on the internal side. The limit mask also controls which base bits can be written. Where a mask bit is clear, the matching base bit is forced to zero and ignores writes. The window size is therefore set by writing the limit first. Bit 0 of the limit word is a claim-disable switch. Bits 11:1 of the limit are reserved.

Each incoming address arrives as a valid/ready request together with a flag that marks memory cycles. The block compares the address with the masked base and registers the outcome into a one-entry response stage. The outcome is a claim flag plus the translated internal address. The translated address takes the masked upper bits from the translation value and passes every other bit through from the request. A request is accepted when `lk_req_valid` and `lk_req_ready` are both high at a clock edge. `lk_req_ready` is high when the response stage is empty, or when its current response is being taken in the same cycle (`lk_rsp_ready` high). A response that is held back stays valid and unchanged until `lk_rsp_ready` rises. Register values are sampled when a request is accepted, so later register writes do not alter a pending response.

Top module: `inbound_window_xlate`

## Requirements
- R1: After reset, the limit word reads 0xFF000000 (a 16 MB window with claiming enabled), and the base and translation words read 0. The lookup port reports `lk_req_ready`=1 and `lk_rsp_valid`=0.
- R2: A base write stores `wdata` AND the current limit mask in bits 31:12. Readback shows exactly that value, with bits 11:0 reading 0.
- R3: While limit bits 31:12 are all zero, a base write has no effect and the base reads 0.
- R4: Limit bits 11:1 read as 0 whatever is written to them. Limit bit 0 (claim disable) stores the written value.
- R5: A limit write re-masks the base in the same clock edge. Base bits that become read-only read 0 from the next cycle, and they stay 0 if the mask is later widened again.
- R6: A memory-cycle request claims (`lk_rsp_claim`=1) when `(addr ^ base) & mask` is zero in bits 31:12 and the mask is nonzero. Otherwise it does not claim.
- R7: A request with `lk_req_is_mem`=0, or any request while the mask is all zero, never claims.
- R8: While limit bit 0 is 1, no request claims, even one whose address lies inside the window.
- R9: The translated address is `(value & mask) | (addr & ~mask)` in bits 31:12, followed by `addr[11:0]`. This is reported whether or not the request claims.
- R10: Bits 11:0 of the translation word read 0 and ignore writes. The bits of the translation word below the mask do not affect the translated address.
- R11: The response is valid in the cycle after its request is accepted. While `lk_rsp_valid`=1 and `lk_rsp_ready`=0, the response stays valid and stable and `lk_req_ready` is 0.
- R12: The response reflects the register contents at the accepting edge. Register writes made while the response waits do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wen | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 limit, 1 base, 2 translation, 3 none (reads 0) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational readback of the selected register |
| lk_req_valid | input | 1 | Lookup request valid |
| lk_req_ready | output | 1 | Lookup request can be accepted |
| lk_req_addr | input | 32 | Incoming bus address |
| lk_req_is_mem | input | 1 | Request is a memory cycle |
| lk_rsp_valid | output | 1 | Lookup response valid |
| lk_rsp_ready | input | 1 | Consumer takes the response |
| lk_rsp_claim | output | 1 | Window claims the cycle |
| lk_rsp_addr | output | 32 | Translated internal-bus address |

## Verification
Register readback is combinational, so the bench reads a register one cycle after a write. It samples a full period after the write's edge, at the falling edge. A lookup result is due one register later. The bench raises the request at a falling edge, lets the next rising edge accept it, and checks claim and address at the following falling edge. For the back-pressure case the bench holds `lk_rsp_ready` low across several edges and rewrites the base while the response waits. It checks that the first result is unchanged and that the next request, accepted one cycle after release, sees the new base.

// File: rtl/iwx_pkg.sv
package iwx_pkg;
  typedef enum logic [1:0] {
    SEL_LIMIT = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_XLATE = 2'd2,
    SEL_NONE  = 2'd3
  } iwx_sel_e;
endpackage

// File: rtl/iwx_regs.sv
module iwx_regs
  import iwx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_LSB = 12,
  parameter logic [ADDR_W-1:0] LIMIT_RESET = 32'hFF00_0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wen,
  input  logic [1:0]                   sel,
  input  logic [ADDR_W-1:0]            wdata,
  output logic [ADDR_W-1:0]            rdata,
  output logic [ADDR_W-PAGE_LSB-1:0]   mask,
  output logic [ADDR_W-PAGE_LSB-1:0]   base_pg,
  output logic [ADDR_W-PAGE_LSB-1:0]   xlate_pg,
  output logic                         claim_dis
);
  localparam int UPW = ADDR_W - PAGE_LSB;

  iwx_sel_e        sel_e;
  logic            wr_limit, wr_base, wr_xlate;
  logic [UPW-1:0]  wpage;

  assign sel_e    = iwx_sel_e'(sel);
  assign wpage    = wdata[ADDR_W-1:PAGE_LSB];
  assign wr_limit = wen && (sel_e == SEL_LIMIT);
  assign wr_base  = wen && (sel_e == SEL_BASE);
  assign wr_xlate = wen && (sel_e == SEL_XLATE);

  // limit word: mask in the page bits, claim-disable in bit 0
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= LIMIT_RESET[ADDR_W-1:PAGE_LSB];
      claim_dis <= 1'b0;
    end else if (wr_limit) begin
      mask      <= wpage;
      claim_dis <= wdata[0];
    end
  end

  // base: each bit writable only under its mask bit, re-masked on limit write
  for (genvar i = 0; i < UPW; i++) begin : g_base_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_pg[i] <= 1'b0;
      end else if (wr_limit) begin
        base_pg[i] <= base_pg[i] & wpage[i];
      end else if (wr_base) begin
        base_pg[i] <= wpage[i] & mask[i];
      end
    end
  end

  // translation word: page bits only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlate_pg <= '0;
    end else if (wr_xlate) begin
      xlate_pg <= wpage;
    end
  end

  always_comb begin
    unique case (sel_e)
      SEL_LIMIT: rdata = {mask, {(PAGE_LSB-1){1'b0}}, claim_dis};
      SEL_BASE:  rdata = {base_pg, {PAGE_LSB{1'b0}}};
      SEL_XLATE: rdata = {xlate_pg, {PAGE_LSB{1'b0}}};
      default:   rdata = '0;
    endcase
  end

  // R2: base never holds a bit outside the mask
  assert_base_in_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (base_pg & ~mask) == '0);

  // R3: write under an empty mask leaves base at zero
  assert_zero_mask_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && mask == '0) |=> base_pg == '0);

  // R5: limit write clears newly read-only base bits at once
  assert_limit_remask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_limit |=> (base_pg & ~$past(wpage)) == '0);
endmodule

// File: rtl/iwx_lookup.sv
module iwx_lookup #(
  parameter int ADDR_W = 32,
  parameter int PAGE_LSB = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic                        req_is_mem,
  input  logic [ADDR_W-PAGE_LSB-1:0]  mask,
  input  logic [ADDR_W-PAGE_LSB-1:0]  base_pg,
  input  logic [ADDR_W-PAGE_LSB-1:0]  xlate_pg,
  input  logic                        claim_dis,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_claim,
  output logic [ADDR_W-1:0]           rsp_addr
);
  localparam int UPW = ADDR_W - PAGE_LSB;

  logic            accept;
  logic [UPW-1:0]  req_pg;
  logic            win_en, in_win, claim_d;
  logic [UPW-1:0]  out_pg;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign req_pg    = req_addr[ADDR_W-1:PAGE_LSB];

  assign win_en  = |mask;
  assign in_win  = ((req_pg ^ base_pg) & mask) == '0;
  assign claim_d = req_is_mem && win_en && in_win && !claim_dis;
  assign out_pg  = (xlate_pg & mask) | (req_pg & ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_claim <= 1'b0;
      rsp_addr  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_claim <= claim_d;
      rsp_addr  <= {out_pg, req_addr[PAGE_LSB-1:0]};
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R11: response follows acceptance by one cycle
  assert_rsp_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R11: a held response does not move
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_claim) && $stable(rsp_addr));

  // R7: non-memory cycles never claim
  assert_nonmem_no_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_is_mem) |=> !rsp_claim);

  // R8: claim disable blocks every claim
  assert_claim_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && claim_dis) |=> !rsp_claim);

  // R9: offset within the page passes through
  assert_offset_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_addr[PAGE_LSB-1:0] == $past(req_addr[PAGE_LSB-1:0]));
endmodule

// File: rtl/inbound_window_xlate.sv
module inbound_window_xlate #(
  parameter int ADDR_W = 32,
  parameter int PAGE_LSB = 12,
  parameter logic [ADDR_W-1:0] LIMIT_RESET = 32'hFF00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wen,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              lk_req_valid,
  output logic              lk_req_ready,
  input  logic [ADDR_W-1:0] lk_req_addr,
  input  logic              lk_req_is_mem,
  output logic              lk_rsp_valid,
  input  logic              lk_rsp_ready,
  output logic              lk_rsp_claim,
  output logic [ADDR_W-1:0] lk_rsp_addr
);
  localparam int UPW = ADDR_W - PAGE_LSB;

  logic [UPW-1:0] mask, base_pg, xlate_pg;
  logic           claim_dis;

  iwx_regs #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .LIMIT_RESET(LIMIT_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wen(cfg_wen), .sel(cfg_sel), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .mask(mask), .base_pg(base_pg), .xlate_pg(xlate_pg), .claim_dis(claim_dis)
  );

  iwx_lookup #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)
  ) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .req_valid(lk_req_valid), .req_ready(lk_req_ready),
    .req_addr(lk_req_addr), .req_is_mem(lk_req_is_mem),
    .mask(mask), .base_pg(base_pg), .xlate_pg(xlate_pg), .claim_dis(claim_dis),
    .rsp_valid(lk_rsp_valid), .rsp_ready(lk_rsp_ready),
    .rsp_claim(lk_rsp_claim), .rsp_addr(lk_rsp_addr)
  );
endmodule

// File: tb/inbound_window_xlate_tb_top.sv
module inbound_window_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wen = 1'b0;
  logic [1:0]  cfg_sel = 2'd3;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_req_valid = 1'b0;
  logic        lk_req_ready;
  logic [31:0] lk_req_addr = '0;
  logic        lk_req_is_mem = 1'b0;
  logic        lk_rsp_valid;
  logic        lk_rsp_ready = 1'b1;
  logic        lk_rsp_claim;
  logic [31:0] lk_rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  inbound_window_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wen(cfg_wen), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lk_req_valid(lk_req_valid), .lk_req_ready(lk_req_ready),
    .lk_req_addr(lk_req_addr), .lk_req_is_mem(lk_req_is_mem),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_ready(lk_rsp_ready),
    .lk_rsp_claim(lk_rsp_claim), .lk_rsp_addr(lk_rsp_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wen = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wen = 1'b0;
  endtask

  task automatic reg_check(input string req, input logic [1:0] sel, input logic [31:0] exp);
    cfg_sel = sel;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic lookup(input string req, input logic [31:0] addr, input logic mem,
                        input logic exp_claim, input logic [31:0] exp_addr);
    @(negedge clk);
    lk_rsp_ready = 1'b1;
    lk_req_valid = 1'b1; lk_req_addr = addr; lk_req_is_mem = mem;
    @(negedge clk);
    lk_req_valid = 1'b0;
    check({req, " valid"}, {31'd0, lk_rsp_valid}, 32'd1);
    check({req, " claim"}, {31'd0, lk_rsp_claim}, {31'd0, exp_claim});
    check({req, " addr"}, lk_rsp_addr, exp_addr);
  endtask

  task automatic t_reset;
    @(negedge clk);
    reg_check("R1 limit", 2'd0, 32'hFF00_0000);
    reg_check("R1 base", 2'd1, 32'h0);
    reg_check("R1 xlate", 2'd2, 32'h0);
    check("R1 req_ready", {31'd0, lk_req_ready}, 32'd1);
    check("R1 rsp_valid", {31'd0, lk_rsp_valid}, 32'd0);
  endtask

  task automatic t_base_and_value;
    reg_write(2'd1, 32'h1234_5678);
    reg_check("R2 base masked", 2'd1, 32'h1200_0000);
    reg_write(2'd2, 32'hABCD_EFFF);
    reg_check("R10 xlate low bits", 2'd2, 32'hABCD_E000);
  endtask

  task automatic t_hit_translate;
    lookup("R6 R9 R10 hit", 32'h12AB_C123, 1'b1, 1'b1, 32'hABAB_C123);
    lookup("R6 R9 miss", 32'h1300_0000, 1'b1, 1'b0, 32'hAB00_0000);
    lookup("R6 edge top", 32'h12FF_FFFF, 1'b1, 1'b1, 32'hABFF_FFFF);
  endtask

  task automatic t_nonmem;
    lookup("R7 non-mem", 32'h12AB_C123, 1'b0, 1'b0, 32'hABAB_C123);
  endtask

  task automatic t_claim_disable;
    reg_write(2'd0, 32'hFF00_0FFF);
    reg_check("R4 reserved", 2'd0, 32'hFF00_0001);
    lookup("R8 disabled hit", 32'h1200_0040, 1'b1, 1'b0, 32'hAB00_0040);
    reg_write(2'd0, 32'hFF00_0000);
    reg_check("R4 bit0 clear", 2'd0, 32'hFF00_0000);
    lookup("R8 re-enabled", 32'h1200_0040, 1'b1, 1'b1, 32'hAB00_0040);
  endtask

  task automatic t_remask;
    reg_write(2'd0, 32'hFFFF_F000);
    reg_write(2'd1, 32'h1234_5678);
    reg_check("R2 full mask", 2'd1, 32'h1234_5000);
    reg_write(2'd0, 32'hFF00_0000);
    reg_check("R5 remask", 2'd1, 32'h1200_0000);
    reg_write(2'd0, 32'hFFFF_F000);
    reg_check("R5 bits lost", 2'd1, 32'h1200_0000);
    lookup("R6 R9 4k window", 32'h1200_0ABC, 1'b1, 1'b1, 32'hABCD_EABC);
    reg_write(2'd0, 32'hFF00_0000);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    lk_rsp_ready = 1'b0;
    lk_req_valid = 1'b1; lk_req_addr = 32'h1200_0010; lk_req_is_mem = 1'b1;
    @(negedge clk);
    lk_req_addr = 32'h5500_0020;
    check("R11 valid", {31'd0, lk_rsp_valid}, 32'd1);
    check("R11 ready low", {31'd0, lk_req_ready}, 32'd0);
    cfg_wen = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h5500_0000;
    @(negedge clk);
    cfg_wen = 1'b0;
    @(negedge clk);
    check("R11 R12 held claim", {31'd0, lk_rsp_claim}, 32'd1);
    check("R11 R12 held addr", lk_rsp_addr, 32'hAB00_0010);
    check("R11 still valid", {31'd0, lk_rsp_valid}, 32'd1);
    lk_rsp_ready = 1'b1;
    #1;
    check("R11 ready on release", {31'd0, lk_req_ready}, 32'd1);
    @(negedge clk);
    lk_req_valid = 1'b0;
    check("R12 new base claim", {31'd0, lk_rsp_claim}, 32'd1);
    check("R12 new base addr", lk_rsp_addr, 32'hAB00_0020);
    @(negedge clk);
    check("R11 drained", {31'd0, lk_rsp_valid}, 32'd0);
  endtask

  task automatic t_zero_limit;
    reg_write(2'd0, 32'h0);
    reg_check("R3 base cleared", 2'd1, 32'h0);
    reg_write(2'd1, 32'hFFFF_FFFF);
    reg_check("R3 base ignored", 2'd1, 32'h0);
    lookup("R7 zero mask", 32'h0000_0100, 1'b1, 1'b0, 32'h0000_0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_base_and_value();
    t_hit_translate();
    t_nonmem();
    t_claim_disable();
    t_remask();
    t_backpressure();
    t_zero_limit();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule